// File: doc/BRIEF.md
# Indexed PLL Register Access Port

This block holds the control registers of a clock synthesizer behind a narrow, indirect host window. The host sees three byte locations: an address byte, a data byte, and a clock-control byte. The address byte carries a register index in its upper six bits and a write-enable flag in bit 1. To read a register, the host writes the address byte with the flag clear and then reads the data byte. To write a register, the host writes the address byte with the flag set, writes the data byte once, and then writes the address byte again with the flag clear.

The register set has a reference divider, a general control byte and an extended control byte. It also has a packed post-divider byte that holds one 2-bit code for each of four pixel clocks, with clock n's code at bits 2n+1:2n. Each pixel clock also has its own 8-bit feedback divider. The low two bits of the clock-control byte select the active pixel clock. The block drives that selection, the selected clock's post-divider code and its feedback divider onto dedicated outputs for the synthesizer.

Writes pass through a small state machine with three states. IDLE means no write is permitted. ARMED means one data write is permitted. SPENT means the permitted write has been used. The transitions are as follows. An address write with the flag set goes to ARMED from any state ("arm"). An address write with the flag clear goes to IDLE ("disarm"). A data write in ARMED commits the byte and goes to SPENT ("commit"). Every other event keeps the current state.

Top module: `pll_index_port`

## Requirements
- R1: A synchronous active-high reset sets every register to zero. It also clears the stored address byte and the clock select, and returns the write state machine to IDLE.
- R2: In the address byte, bits 7:2 hold the register index and bit 1 is the write-enable flag. Bit 0 is not stored. Reading the address byte returns the stored index and flag, with bit 0 as 0.
- R3: Reading the data byte returns the register at the current index in the same cycle, with no side effect.
- R4: When the flag is set, a data-byte write stores the byte into the indexed register. The new value is readable from the next cycle on.
- R5: A data-byte write while the flag is clear is ignored and leaves every register unchanged.
- R6: Each arming permits exactly one data write. Further data writes are ignored until the address byte is written again with the flag set.
- R7: An index with no register reads as zero, and a write to it changes nothing.
- R8: The register map is: index 1 reference divider, 2 general control, 3 extended control, 4 packed post-divider, and 8+n the feedback divider of pixel clock n (n = 0..3).
- R9: pix_post_code equals bits 2s+1:2s of the post-divider register, where s is the active clock select.
- R10: pix_fb_div equals the full 8-bit feedback divider register at index 8+s.
- R11: A write to the clock-control byte keeps only its low two bits as the clock select. Reading that byte returns the select with bits 7:2 as zero.
- R12: bus_sel encodes the byte location: 0 is the address byte, 1 the data byte, 2 the clock-control byte. Code 3 reads as zero and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe for the byte location chosen by bus_sel |
| bus_sel | input | 2 | Byte location: 0 address, 1 data, 2 clock control |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte for the location chosen by bus_sel |
| pix_sel | output | 2 | Active pixel clock select |
| pix_post_code | output | 2 | Post-divider code of the selected pixel clock |
| pix_fb_div | output | 8 | Feedback divider of the selected pixel clock |

## Verification
A wrong write state shows one cycle after the offending data write. Either a register that should have stayed put changes, or an expected change is missing. Both show at once on bus_rdata when the data byte is selected, and on pix_fb_div or pix_post_code when the touched register belongs to the selected clock. A wrong index or a wrong field slice shows as soon as the clock select points at the affected pixel clock. The bench therefore steps the select through all four clocks after loading distinct values.

// File: rtl/pllp_pkg.sv
package pllp_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 6;
    localparam int CODE_W = 2;

    localparam logic [1:0] LOC_ADDR = 2'd0;
    localparam logic [1:0] LOC_DATA = 2'd1;
    localparam logic [1:0] LOC_CLK  = 2'd2;

    localparam logic [IDX_W-1:0] IX_REFDIV = 6'd1;
    localparam logic [IDX_W-1:0] IX_GEN    = 6'd2;
    localparam logic [IDX_W-1:0] IX_EXT    = 6'd3;
    localparam logic [IDX_W-1:0] IX_POST   = 6'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SPENT = 2'd2
    } wr_state_t;
endpackage

// File: rtl/pllp_wr_fsm.sv
module pllp_wr_fsm
    import pllp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic addr_wr,
    input  logic addr_flag,
    input  logic data_wr,
    output logic commit
);
    wr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (addr_wr) begin
            state_d = addr_flag ? ST_ARMED : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: if (data_wr) state_d = ST_SPENT;
                ST_SPENT: state_d = ST_SPENT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            ST_ARMED: commit = data_wr;
            ST_IDLE, ST_SPENT: commit = 1'b0;
            default:  commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pllp_regs.sv
module pllp_regs
    import pllp_pkg::*;
#(
    parameter int NUM_PIX = 4,
    parameter int FB_BASE = 8,
    localparam int SEL_W  = $clog2(NUM_PIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [SEL_W-1:0]  pix_sel,
    output logic [CODE_W-1:0] post_code,
    output logic [BYTE_W-1:0] fb_div
);
    logic [BYTE_W-1:0] ref_q, gen_q, ext_q, post_q;
    logic [BYTE_W-1:0] fb_q [NUM_PIX];

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            gen_q  <= '0;
            ext_q  <= '0;
            post_q <= '0;
        end else if (wr_en) begin
            if (idx == IX_REFDIV) ref_q  <= wr_data;
            if (idx == IX_GEN)    gen_q  <= wr_data;
            if (idx == IX_EXT)    ext_q  <= wr_data;
            if (idx == IX_POST)   post_q <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_PIX; g++) begin : g_fb
        localparam logic [IDX_W-1:0] MY_IX = IDX_W'(FB_BASE + g);
        always_ff @(posedge clk) begin
            if (rst)                          fb_q[g] <= '0;
            else if (wr_en && idx == MY_IX)   fb_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (idx == IX_REFDIV) rd_data = ref_q;
        if (idx == IX_GEN)    rd_data = gen_q;
        if (idx == IX_EXT)    rd_data = ext_q;
        if (idx == IX_POST)   rd_data = post_q;
        for (int k = 0; k < NUM_PIX; k++) begin
            if (idx == IDX_W'(FB_BASE + k)) rd_data = fb_q[k];
        end
    end

    assign post_code = post_q[CODE_W*pix_sel +: CODE_W];
    assign fb_div    = fb_q[pix_sel];
endmodule

// File: rtl/pll_index_port.sv
module pll_index_port
    import pllp_pkg::*;
#(
    parameter int NUM_PIX = 4,
    parameter int FB_BASE = 8,
    localparam int SEL_W  = $clog2(NUM_PIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_sel,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [SEL_W-1:0]  pix_sel,
    output logic [CODE_W-1:0] pix_post_code,
    output logic [BYTE_W-1:0] pix_fb_div
);
    logic [IDX_W-1:0]  idx_q;
    logic              flag_q;
    logic [SEL_W-1:0]  csel_q;
    logic              addr_wr, data_wr, clk_wr, commit;
    logic [BYTE_W-1:0] reg_rd;

    assign addr_wr = bus_wr && (bus_sel == LOC_ADDR);
    assign data_wr = bus_wr && (bus_sel == LOC_DATA);
    assign clk_wr  = bus_wr && (bus_sel == LOC_CLK);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            flag_q <= 1'b0;
            csel_q <= '0;
        end else begin
            if (addr_wr) begin
                idx_q  <= bus_wdata[BYTE_W-1:2];
                flag_q <= bus_wdata[1];
            end
            if (clk_wr) csel_q <= bus_wdata[SEL_W-1:0];
        end
    end

    pllp_wr_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .addr_wr   (addr_wr),
        .addr_flag (bus_wdata[1]),
        .data_wr   (data_wr),
        .commit    (commit)
    );

    pllp_regs #(.NUM_PIX(NUM_PIX), .FB_BASE(FB_BASE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (commit),
        .idx       (idx_q),
        .wr_data   (bus_wdata),
        .rd_data   (reg_rd),
        .pix_sel   (csel_q),
        .post_code (pix_post_code),
        .fb_div    (pix_fb_div)
    );

    always_comb begin
        unique case (bus_sel)
            LOC_ADDR: bus_rdata = {idx_q, flag_q, 1'b0};
            LOC_DATA: bus_rdata = reg_rd;
            LOC_CLK:  bus_rdata = BYTE_W'(csel_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign pix_sel = csel_q;
endmodule

// File: rtl/pll_index_port_chk.sv
module pll_index_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [1:0] bus_sel,
    input logic [7:0] bus_rdata,
    input logic [1:0] pix_sel,
    input logic [1:0] pix_post_code,
    input logic [7:0] pix_fb_div,
    input logic       flag,
    input logic       commit
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (pix_sel == 2'd0 && pix_post_code == 2'd0 && pix_fb_div == 8'd0));

    // R6
    single_commit_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    // R5
    unarmed_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == 2'd1 && !flag) |=> ($stable(pix_fb_div) && $stable(pix_post_code)));

    // R11
    select_only_by_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel != 2'd2) |=> $stable(pix_sel));

    // R2
    addr_bit0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 2'd0) |-> (bus_rdata[0] == 1'b0));

    // R12
    unused_loc_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 2'd3) |-> (bus_rdata == 8'd0));
endmodule

bind pll_index_port pll_index_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_sel       (bus_sel),
    .bus_rdata     (bus_rdata),
    .pix_sel       (pix_sel),
    .pix_post_code (pix_post_code),
    .pix_fb_div    (pix_fb_div),
    .flag          (flag_q),
    .commit        (commit)
);

// File: tb/pll_index_port_test.sv
`timescale 1ns/1ps
module pll_index_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [1:0] pix_sel;
    logic [1:0] pix_post_code;
    logic [7:0] pix_fb_div;

    int checks = 0;
    int errors = 0;

    // behavioural reference
    int mem [64];
    int m_addr = 0;
    bit m_may_write = 0;
    int m_sel = 0;

    always #2.5 clk = ~clk;

    pll_index_port uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_sel(pix_sel),
        .pix_post_code(pix_post_code), .pix_fb_div(pix_fb_div)
    );

    function automatic bit has_reg(input int i);
        return (i >= 1 && i <= 4) || (i >= 8 && i <= 11);
    endfunction

    function automatic int model_rd(input int loc);
        case (loc)
            0: return m_addr & 8'hFE;
            1: return has_reg(m_addr >> 2) ? mem[m_addr >> 2] : 0;
            2: return m_sel;
            default: return 0;
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) mem[i] = 0;
        m_addr = 0; m_may_write = 0; m_sel = 0;
    endtask

    task automatic model_write(input int loc, input int d);
        case (loc)
            0: begin m_addr = d & 8'hFE; m_may_write = d[1]; end
            1: if (m_may_write) begin
                   if (has_reg(m_addr >> 2)) mem[m_addr >> 2] = d;
                   m_may_write = 0;
               end
            2: m_sel = d & 3;
            default: ;
        endcase
    endtask

    task automatic compare_all();
        check(bus_rdata, model_rd(bus_sel), "R3/R12 model rdata");
        check(pix_sel, m_sel, "R11 model pix_sel");
        check(pix_post_code, (mem[4] >> (2 * m_sel)) & 3, "R9 model post code");
        check(pix_fb_div, mem[8 + m_sel], "R10 model fb div");
    endtask

    task automatic cyc(input logic w, input logic [1:0] s, input logic [7:0] d);
        bus_wr = w; bus_sel = s; bus_wdata = d;
        @(posedge clk);
        if (w) model_write(s, d);
        @(negedge clk);
        bus_wr = 1'b0;
        compare_all();
    endtask

    task automatic reg_write(input int idx, input logic [7:0] d);
        cyc(1'b1, 2'd0, 8'((idx << 2) | 2));
        cyc(1'b1, 2'd1, d);
        cyc(1'b1, 2'd0, 8'(idx << 2));
    endtask

    task automatic reg_read(input int idx, input int exp, input string tag);
        cyc(1'b1, 2'd0, 8'(idx << 2));
        bus_sel = 2'd1;
        #0.5;
        check(bus_rdata, exp, tag);
        check(bus_rdata, model_rd(1), "R3 model read");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state on every location and output
        for (int l = 0; l < 4; l++) begin
            bus_sel = 2'(l); #0.5;
            check(bus_rdata, 0, "R1 reset read");
        end
        check(pix_sel, 0, "R1 reset pix_sel");
        check(pix_fb_div, 0, "R1 reset fb");
        check(pix_post_code, 0, "R1 reset post");
        @(negedge clk);

        // R4 / R8: full write protocol to reference divider
        reg_write(1, 8'h5A);
        reg_read(1, 8'h5A, "R4 R8 reference divider");
        reg_write(2, 8'hC3);
        reg_read(2, 8'hC3, "R8 general control");
        reg_write(3, 8'h0F);
        reg_read(3, 8'h0F, "R8 extended control");

        // R5: data write with flag clear
        cyc(1'b1, 2'd0, 8'(2 << 2));
        cyc(1'b1, 2'd1, 8'h33);
        reg_read(2, 8'hC3, "R5 unarmed write ignored");

        // R6: second data write after one arming
        cyc(1'b1, 2'd0, 8'((3 << 2) | 2));
        cyc(1'b1, 2'd1, 8'h11);
        cyc(1'b1, 2'd1, 8'h22);
        reg_read(3, 8'h11, "R6 single write per arming");

        // R7: unmapped index
        reg_write(5, 8'h77);
        reg_read(5, 0, "R7 unmapped read zero");
        reg_read(1, 8'h5A, "R7 neighbours unchanged");
        reg_read(63, 0, "R7 top index zero");

        // R9 / R10: post-divider packing and feedback dividers
        reg_write(4, 8'hE4);
        reg_write(8, 8'h80);
        reg_write(9, 8'h91);
        reg_write(10, 8'hA2);
        reg_write(11, 8'hFF);
        for (int s = 0; s < 4; s++) begin
            cyc(1'b1, 2'd2, 8'(8'hFC | s));
            check(pix_sel, s, "R11 select low bits");
            check(pix_post_code, s, "R9 packed code at 2n");
            check(pix_fb_div, (s == 0) ? 8'h80 : (s == 1) ? 8'h91 : (s == 2) ? 8'hA2 : 8'hFF,
                  "R10 fb divider at base+n");
        end
        check(bus_rdata, 3, "R11 clock byte readback");

        // R9 with a different pattern
        reg_write(4, 8'h1B);
        check(pix_post_code, 0, "R9 clock3 code of 0x1B");
        cyc(1'b1, 2'd2, 8'h01);
        check(pix_post_code, 2, "R9 clock1 code of 0x1B");

        // R2: address byte layout and readback
        cyc(1'b1, 2'd0, 8'hFF);
        check(bus_rdata, 8'hFE, "R2 address readback");
        cyc(1'b1, 2'd0, 8'h21);
        check(bus_rdata, 8'h20, "R2 bit0 dropped flag clear");

        // R12: unused location
        cyc(1'b1, 2'd3, 8'hAA);
        check(bus_rdata, 0, "R12 unused location");
        check(pix_sel, 1, "R12 write to unused ignored");
        reg_read(9, 8'h91, "R12 registers intact");

        // R1: reset again clears written state
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        reg_read(8, 0, "R1 reset clears fb");
        check(pix_sel, 0, "R1 reset clears select");
        cyc(1'b1, 2'd1, 8'h44);
        reg_read(8, 0, "R1 state idle after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule